// File: doc/BRIEF.md
# Memory-Side Translation Stamp Validator

This block sits at the memory side of a system whose cores cache address translations without eager invalidation. Every cached translation carries a small stamp: the generation its page had when the translation was loaded. The validator holds the authoritative page table and a wrapping generation counter for each virtual page. Rewriting a page's mapping stores the new physical page and advances that page's generation by one.

Each memory access presents a requester tag, the virtual page, the physical page the requester's TLB produced, and the stamp from that TLB entry. The validator compares the stamp with the page's present generation. If they are equal, the access goes to memory unchanged. If they differ, the access goes to memory with the authoritative physical page instead. A refill message also goes back to the requester, carrying the fresh mapping and generation so that its TLB can repair the entry.

The lookup is combinational. The verdict and both output channels are registered, so results appear one cycle after the access. A mapping write and an access to the same page in the same cycle are resolved write-first.

Top module: `stamp_validator`

## Requirements
- R1: After reset, mem_valid and refill_valid are 0, every page's generation is 0, and (with the default identity reset) page i maps to physical page i.
- R2: A cycle with pte_we high stores pte_ppn for page pte_vpn and increments that page's generation by one; other pages keep their mapping and generation.
- R3: An access whose acc_stamp equals the page's present generation is forwarded with acc_ppn unchanged, and refill_valid stays 0.
- R4: An access whose acc_stamp differs from the page's present generation is forwarded with the page table's physical page, never with acc_ppn, and refill_valid is 1.
- R5: A refill carries the accessing requester's tag, the virtual page, the corrected physical page and the page's present generation.
- R6: When pte_we and acc_valid target the same page in one cycle, the access is judged against the updated mapping and generation.
- R7: mem_valid is high exactly one cycle after a cycle with acc_valid high. Without an access, neither mem_valid nor refill_valid rises, even when a mapping write occurs.
- R8: Generations are GEN_W bits (8 by default) and wrap from 255 to 0. Only equality counts as current.
- R9: mem_id and mem_vpn repeat the access's acc_id and acc_vpn one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pte_we | input | 1 | Mapping write strobe |
| pte_vpn | input | VPN_W | Page being remapped |
| pte_ppn | input | PPN_W | New physical page |
| acc_valid | input | 1 | Access present |
| acc_id | input | ID_W | Requester tag |
| acc_vpn | input | VPN_W | Accessed virtual page |
| acc_ppn | input | PPN_W | Physical page from requester's TLB |
| acc_stamp | input | GEN_W | Generation stamp from requester's TLB |
| mem_valid | output | 1 | Access forwarded to memory |
| mem_id | output | ID_W | Forwarded requester tag |
| mem_vpn | output | VPN_W | Forwarded virtual page |
| mem_ppn | output | PPN_W | Physical page used for memory |
| refill_valid | output | 1 | Repair message to requester |
| refill_id | output | ID_W | Requester to repair |
| refill_vpn | output | VPN_W | Page to repair |
| refill_ppn | output | PPN_W | Fresh physical page |
| refill_gen | output | GEN_W | Fresh generation |

## Verification
The bench goes after the same-cycle write-and-access collision. A read-first design would pass an already outdated stamp and send memory the old physical page. It drives one page through a full generation wrap. A design that compares with magnitude, or saturates its counter, would flag the wrapped stamp as stale or miss the stale stamp at 255. It checks that a mapping write with no access raises neither output strobe, and that refill fields report the post-increment generation rather than the old one. A long random phase closes the loop with modelled TLBs that absorb refills. In that phase every forwarded physical page must equal the page table's present mapping.

// File: rtl/sv_pkg.sv
package sv_pkg;
   typedef enum logic {
      VERDICT_CURRENT = 1'b0,
      VERDICT_STALE   = 1'b1
   } verdict_e;
endpackage

// File: rtl/sv_page_table.sv
module sv_page_table #(
   parameter int VPN_W          = 6,
   parameter int PPN_W          = 10,
   parameter int GEN_W          = 8,
   parameter bit IDENTITY_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [VPN_W-1:0] rd_vpn,
   output logic [PPN_W-1:0] rd_ppn,
   output logic [GEN_W-1:0] rd_gen
);
   localparam int PAGES = 1 << VPN_W;

   logic [PPN_W-1:0] ppn_q   [PAGES];
   logic [GEN_W-1:0] gen_q   [PAGES];
   logic [PPN_W-1:0] rst_ppn [PAGES];

   for (genvar i = 0; i < PAGES; i++) begin : g_rst
      if (IDENTITY_RESET) begin : g_ident
         assign rst_ppn[i] = PPN_W'(i);
      end else begin : g_zero
         assign rst_ppn[i] = '0;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PAGES; i++) begin
         if (!rst_n) begin
            ppn_q[i] <= rst_ppn[i];
            gen_q[i] <= '0;
         end else if (wr_en && (wr_vpn == VPN_W'(i))) begin
            ppn_q[i] <= wr_ppn;
            gen_q[i] <= gen_q[i] + GEN_W'(1);
         end
      end
   end

   // write-first: a same-cycle write to the read page is visible now
   logic collide;
   assign collide = wr_en && (wr_vpn == rd_vpn);

   always_comb begin
      if (collide) begin
         rd_ppn = wr_ppn;
         rd_gen = gen_q[rd_vpn] + GEN_W'(1);
      end else begin
         rd_ppn = ppn_q[rd_vpn];
         rd_gen = gen_q[rd_vpn];
      end
   end
endmodule

// File: rtl/sv_stamp_cmp.sv
module sv_stamp_cmp #(
   parameter int GEN_W = 8
) (
   input  logic [GEN_W-1:0] stamp,
   input  logic [GEN_W-1:0] cur_gen,
   output sv_pkg::verdict_e verdict
);
   // equality only: wrapping counters have no meaningful order
   assign verdict = (stamp == cur_gen) ? sv_pkg::VERDICT_CURRENT
                                       : sv_pkg::VERDICT_STALE;
endmodule

// File: rtl/sv_out_stage.sv
module sv_out_stage #(
   parameter int VPN_W = 6,
   parameter int PPN_W = 10,
   parameter int GEN_W = 8,
   parameter int ID_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  sv_pkg::verdict_e in_verdict,
   input  logic [ID_W-1:0]  in_id,
   input  logic [VPN_W-1:0] in_vpn,
   input  logic [PPN_W-1:0] in_req_ppn,
   input  logic [PPN_W-1:0] in_tbl_ppn,
   input  logic [GEN_W-1:0] in_gen,
   output logic             mem_valid,
   output logic [ID_W-1:0]  mem_id,
   output logic [VPN_W-1:0] mem_vpn,
   output logic [PPN_W-1:0] mem_ppn,
   output logic             refill_valid,
   output logic [GEN_W-1:0] refill_gen
);
   logic stale;
   assign stale = (in_verdict == sv_pkg::VERDICT_STALE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_valid    <= 1'b0;
         refill_valid <= 1'b0;
         mem_id       <= '0;
         mem_vpn      <= '0;
         mem_ppn      <= '0;
         refill_gen   <= '0;
      end else begin
         mem_valid    <= in_valid;
         refill_valid <= in_valid && stale;
         if (in_valid) begin
            mem_id     <= in_id;
            mem_vpn    <= in_vpn;
            mem_ppn    <= stale ? in_tbl_ppn : in_req_ppn;
            refill_gen <= in_gen;
         end
      end
   end
endmodule

// File: rtl/stamp_validator.sv
module stamp_validator #(
   parameter int VPN_W          = 6,
   parameter int PPN_W          = 10,
   parameter int GEN_W          = 8,
   parameter int ID_W           = 3,
   parameter bit IDENTITY_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pte_we,
   input  logic [VPN_W-1:0] pte_vpn,
   input  logic [PPN_W-1:0] pte_ppn,
   input  logic             acc_valid,
   input  logic [ID_W-1:0]  acc_id,
   input  logic [VPN_W-1:0] acc_vpn,
   input  logic [PPN_W-1:0] acc_ppn,
   input  logic [GEN_W-1:0] acc_stamp,
   output logic             mem_valid,
   output logic [ID_W-1:0]  mem_id,
   output logic [VPN_W-1:0] mem_vpn,
   output logic [PPN_W-1:0] mem_ppn,
   output logic             refill_valid,
   output logic [ID_W-1:0]  refill_id,
   output logic [VPN_W-1:0] refill_vpn,
   output logic [PPN_W-1:0] refill_ppn,
   output logic [GEN_W-1:0] refill_gen
);
   if (VPN_W < 1 || VPN_W > 10) begin : g_bad_vpn
      $error("stamp_validator: VPN_W out of range");
   end
   if (GEN_W < 2 || GEN_W > 32) begin : g_bad_gen
      $error("stamp_validator: GEN_W out of range");
   end
   if (PPN_W < 1 || ID_W < 1) begin : g_bad_w
      $error("stamp_validator: PPN_W and ID_W must be positive");
   end

   logic [PPN_W-1:0] rd_ppn;
   logic [GEN_W-1:0] rd_gen;
   sv_pkg::verdict_e verdict;

   sv_page_table #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .GEN_W(GEN_W),
      .IDENTITY_RESET(IDENTITY_RESET)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(pte_we), .wr_vpn(pte_vpn), .wr_ppn(pte_ppn),
      .rd_vpn(acc_vpn), .rd_ppn(rd_ppn), .rd_gen(rd_gen)
   );

   sv_stamp_cmp #(.GEN_W(GEN_W)) u_cmp (
      .stamp(acc_stamp), .cur_gen(rd_gen), .verdict(verdict)
   );

   sv_out_stage #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .GEN_W(GEN_W), .ID_W(ID_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(acc_valid), .in_verdict(verdict),
      .in_id(acc_id), .in_vpn(acc_vpn),
      .in_req_ppn(acc_ppn), .in_tbl_ppn(rd_ppn), .in_gen(rd_gen),
      .mem_valid(mem_valid), .mem_id(mem_id), .mem_vpn(mem_vpn),
      .mem_ppn(mem_ppn), .refill_valid(refill_valid),
      .refill_gen(refill_gen)
   );

   // a refill always describes the access that is being forwarded
   assign refill_id  = mem_id;
   assign refill_vpn = mem_vpn;
   assign refill_ppn = mem_ppn;
endmodule

// File: rtl/stamp_validator_chk.sv
module stamp_validator_chk #(
   parameter int VPN_W = 6,
   parameter int PPN_W = 10,
   parameter int GEN_W = 8,
   parameter int ID_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic [ID_W-1:0]  acc_id,
   input logic [VPN_W-1:0] acc_vpn,
   input logic [PPN_W-1:0] acc_ppn,
   input logic [GEN_W-1:0] acc_stamp,
   input logic [PPN_W-1:0] rd_ppn,
   input logic [GEN_W-1:0] rd_gen,
   input logic             mem_valid,
   input logic [ID_W-1:0]  mem_id,
   input logic [VPN_W-1:0] mem_vpn,
   input logic [PPN_W-1:0] mem_ppn,
   input logic             refill_valid,
   input logic [GEN_W-1:0] refill_gen
);
   AST_ACCESS_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> mem_valid); // R7
   AST_NO_SPURIOUS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!mem_valid && !refill_valid)); // R7
   AST_TAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (mem_id == $past(acc_id) && mem_vpn == $past(acc_vpn))); // R9
   AST_CURRENT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_stamp == rd_gen) |=>
         (!refill_valid && mem_ppn == $past(acc_ppn))); // R3
   AST_STALE_REPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_stamp != rd_gen) |=>
         (refill_valid && mem_ppn == $past(rd_ppn))); // R4
   AST_REFILL_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_stamp != rd_gen) |=> (refill_gen == $past(rd_gen))); // R5
endmodule

bind stamp_validator stamp_validator_chk #(
   .VPN_W(VPN_W), .PPN_W(PPN_W), .GEN_W(GEN_W), .ID_W(ID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .acc_valid(acc_valid), .acc_id(acc_id), .acc_vpn(acc_vpn),
   .acc_ppn(acc_ppn), .acc_stamp(acc_stamp),
   .rd_ppn(rd_ppn), .rd_gen(rd_gen),
   .mem_valid(mem_valid), .mem_id(mem_id), .mem_vpn(mem_vpn),
   .mem_ppn(mem_ppn), .refill_valid(refill_valid), .refill_gen(refill_gen)
);

// File: tb/stamp_validator_bench.sv
module stamp_validator_bench;
   localparam int VPN_W = 6;
   localparam int PPN_W = 10;
   localparam int GEN_W = 8;
   localparam int ID_W  = 3;
   localparam int PAGES = 1 << VPN_W;
   localparam int IDS   = 1 << ID_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             pte_we = 0;
   logic [VPN_W-1:0] pte_vpn = 0;
   logic [PPN_W-1:0] pte_ppn = 0;
   logic             acc_valid = 0;
   logic [ID_W-1:0]  acc_id = 0;
   logic [VPN_W-1:0] acc_vpn = 0;
   logic [PPN_W-1:0] acc_ppn = 0;
   logic [GEN_W-1:0] acc_stamp = 0;
   logic             mem_valid, refill_valid;
   logic [ID_W-1:0]  mem_id, refill_id;
   logic [VPN_W-1:0] mem_vpn, refill_vpn;
   logic [PPN_W-1:0] mem_ppn, refill_ppn;
   logic [GEN_W-1:0] refill_gen;

   stamp_validator u_stamp_validator (.*);

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // behavioural reference: authoritative table and per-requester TLBs
   int m_ppn [PAGES];
   int m_gen [PAGES];
   int t_ppn [IDS][PAGES];
   int t_gen [IDS][PAGES];

   task automatic chk(string req, string what, int act, int exp);
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive one cycle, update the model write-first, sample after the edge
   task automatic step(string req, bit we, int wv, int wp,
                       bit av, int id, int v, int p, int st);
      bit stale;
      int exp_ppn;
      pte_we = we; pte_vpn = VPN_W'(wv); pte_ppn = PPN_W'(wp);
      acc_valid = av; acc_id = ID_W'(id); acc_vpn = VPN_W'(v);
      acc_ppn = PPN_W'(p); acc_stamp = GEN_W'(st);
      if (we) begin
         m_ppn[wv] = wp;
         m_gen[wv] = (m_gen[wv] + 1) % 256;
      end
      stale   = av && (st != m_gen[v]);
      exp_ppn = stale ? m_ppn[v] : p;
      @(posedge clk); #1;
      vectors++;
      chk(req, "mem_valid", int'(mem_valid), int'(av));
      chk(req, "refill_valid", int'(refill_valid), int'(stale));
      if (av) begin
         chk("R9", "mem_id", int'(mem_id), id);
         chk("R9", "mem_vpn", int'(mem_vpn), v);
         chk(req, "mem_ppn", int'(mem_ppn), exp_ppn);
      end
      if (stale) begin
         chk("R5", "refill_id", int'(refill_id), id);
         chk("R5", "refill_vpn", int'(refill_vpn), v);
         chk("R5", "refill_ppn", int'(refill_ppn), m_ppn[v]);
         chk("R5", "refill_gen", int'(refill_gen), m_gen[v]);
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < PAGES; i++) begin
         m_ppn[i] = i;
         m_gen[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      vectors++;
      chk("R1", "mem_valid", int'(mem_valid), 0);
      chk("R1", "refill_valid", int'(refill_valid), 0);
      rst_n = 1'b1;

      // R1: reset mapping is identity with generation 0
      step("R1", 0, 0, 0, 1, 2, 5, 5, 0);
      step("R1", 0, 0, 0, 1, 3, 63, 63, 0);
      // R2/R4: remap page 5, old stamp is now stale
      step("R2", 1, 5, 'h123, 0, 0, 0, 0, 0);
      step("R4", 0, 0, 0, 1, 1, 5, 5, 0);
      // R3: fresh stamp passes requester's page untouched
      step("R3", 0, 0, 0, 1, 4, 5, 'h123, 1);
      // R2: untouched neighbour keeps mapping and generation
      step("R2", 0, 0, 0, 1, 0, 6, 6, 0);
      // R6: same-cycle write and access to page 5
      step("R6", 1, 5, 'h200, 1, 6, 5, 'h123, 1);
      step("R6", 0, 0, 0, 1, 6, 5, 'h200, 2);
      // R7: write without access raises no strobe
      step("R7", 1, 7, 'h3ff, 0, 0, 0, 0, 0);
      step("R7", 0, 0, 0, 0, 0, 0, 0, 0);
      // R8: drive page 9 through a full wrap
      for (int k = 0; k < 255; k++) step("R2", 1, 9, k, 0, 0, 0, 0, 0);
      step("R8", 0, 0, 0, 1, 5, 9, 9, 0);        // stamp 0 vs gen 255: stale
      step("R8", 0, 0, 0, 1, 5, 9, 254, 255);    // current at 255
      step("R8", 1, 9, 'h2aa, 0, 0, 0, 0, 0);    // wraps to 0
      step("R8", 0, 0, 0, 1, 7, 9, 'h2aa, 0);    // stamp 0 current again
      step("R8", 0, 0, 0, 1, 7, 9, 'h2aa, 255);  // 255 now stale

      // closed loop: TLBs absorb refills; memory never sees a stale page
      for (int i = 0; i < IDS; i++)
         for (int j = 0; j < PAGES; j++) begin
            t_ppn[i][j] = m_ppn[j];
            t_gen[i][j] = m_gen[j];
         end
      for (int c = 0; c < 3000; c++) begin
         bit we, av;
         int wv, wp, id, v;
         we = ($urandom % 8) == 0;
         wv = $urandom % PAGES;
         wp = $urandom % (1 << PPN_W);
         av = ($urandom % 4) != 0;
         id = $urandom % IDS;
         v  = $urandom % PAGES;
         step("R4", we, wv, wp, av, id, v, t_ppn[id][v], t_gen[id][v]);
         if (av) chk("R4", "memory page vs table", int'(mem_ppn), m_ppn[v]);
         if (refill_valid) begin
            t_ppn[refill_id][refill_vpn] = int'(refill_ppn);
            t_gen[refill_id][refill_vpn] = int'(refill_gen);
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule